// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts the direction of conditional branches by running two component predictors side by side and letting a third table pick, per branch, which of the two to trust. The global component is a table of 2-bit saturating counters addressed by the taken/not-taken outcomes of the most recent branches. The local component is two-level. A per-branch history table, addressed by program-counter bits, holds the recent outcomes of that one branch. That pattern then addresses a table of 3-bit saturating counters. A selector table of 2-bit saturating counters, addressed by program-counter bits, chooses between the two.

The lookup side is purely combinational. It takes a PC and returns the final direction, the selector's choice, and both component guesses. The update side takes a resolved branch's PC and outcome. It re-reads every table at that PC, trains both component counters, moves the selector only when the components disagreed in correctness, and shifts the outcome into both histories. Every table size is a parameter. The defaults give 1K entries per table, and the sizes scale up to 4K entries. Target addresses and recovery of speculative history are handled elsewhere.

Top module: `tournament_bp`

## Requirements
- R1: After reset, every 2-bit component counter holds 1, every 3-bit counter holds 3, every selector counter holds 1 and every history is zero. Any lookup then returns all four outputs low.
- R2: A global counter is 2 bits wide and saturates at 0 and 3. It predicts taken when its value is 2 or more. On each update, the counter addressed by the current global history is stepped up on taken and down on not taken.
- R3: A local counter is 3 bits wide and saturates at 0 and 7. It predicts taken when its value is 4 or more. On each update, the counter addressed by the updating branch's local pattern is stepped toward the outcome.
- R4: Each update shifts the outcome into bit 0 of the global history, and the older bits move up one place. Global lookups use the history as it stands before any update in the same cycle.
- R5: The local history entry is selected by PC bits [ALIGN_W +: LHT_IDX_W]. Each update shifts the outcome into bit 0 of that entry.
- R6: The selector entry is selected by PC bits [ALIGN_W +: CHOOSE_IDX_W]. A value of 2 or more selects the local component (`lk_use_local` = 1). On update the entry is incremented (saturating at 3) when only the local guess was right, and decremented (saturating at 0) when only the global guess was right. Otherwise it is unchanged.
- R7: `lk_taken` equals the guess of the component chosen by `lk_use_local`.
- R8: Lookup outputs depend combinationally on `lk_pc` and stored state. An update becomes visible from the next rising clock edge.
- R9: While `up_valid` is low, no table or history changes, whatever `up_pc` and `up_taken` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | PC being looked up |
| lk_taken | output | 1 | Final predicted direction |
| lk_use_local | output | 1 | Selector picks the local component |
| lk_global_taken | output | 1 | Global component guess |
| lk_local_taken | output | 1 | Local component guess |
| up_valid | input | 1 | Train with a resolved branch this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Resolved direction |

## Verification
Four stimulus patterns are used. The first is a branch that alternates, which only the per-branch history can learn. The second is a branch that copies the previous outcome of another branch, which only the shared history can learn. The third is a branch that is nearly always taken, which both components get right, so the selector must not move. The fourth is a run of several PCs that all drive their local patterns to all ones, which exposes a local counter that wraps instead of saturating. A bench-side model built from the requirements predicts all four outputs on every step, before the update is applied. Idle cycles with toggling update data confirm that nothing moves without `up_valid`.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

    // Which component the selector favours; the encoding matches the
    // selector counter's top bit.
    typedef enum logic {
        SIDE_GLOBAL = 1'b0,
        SIDE_LOCAL  = 1'b1
    } side_e;

    // True when exactly one of two component guesses matches the outcome.
    function automatic logic only_one_right(input logic guess_a,
                                            input logic guess_b,
                                            input logic outcome);
        return (guess_a == outcome) != (guess_b == outcome);
    endfunction

endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table #(
    parameter int IDX_W   = 10,
    parameter int CTR_W   = 2,
    parameter int RST_VAL = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_up,
    output logic             upd_taken
);
    localparam int               DEPTH    = 1 << IDX_W;
    localparam logic [CTR_W-1:0] CTR_MAX  = '1;
    localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'(RST_VAL);

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        logic [CTR_W-1:0] val;
    } wr_t;

    logic [CTR_W-1:0] mem_q [DEPTH];
    logic [CTR_W-1:0] cur_ctr;
    wr_t              wr_d;

    always_comb begin
        cur_ctr   = mem_q[upd_idx];
        wr_d.en   = upd_en;
        wr_d.idx  = upd_idx;
        wr_d.val  = cur_ctr;
        if (upd_up && (cur_ctr != CTR_MAX)) begin
            wr_d.val = cur_ctr + 1'b1;
        end else if (!upd_up && (cur_ctr != '0)) begin
            wr_d.val = cur_ctr - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= CTR_INIT;
            end
        end else if (wr_d.en) begin
            mem_q[wr_d.idx] <= wr_d.val;
        end
    end

    assign rd_taken  = mem_q[rd_idx][CTR_W-1];
    assign upd_taken = cur_ctr[CTR_W-1];

    AST_CTR_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_up && (cur_ctr == CTR_MAX)) |=> (mem_q[$past(upd_idx)] == CTR_MAX)); // R2
    AST_CTR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_up && (cur_ctr == '0)) |=> (mem_q[$past(upd_idx)] == '0)); // R3
    AST_CTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> (mem_q[$past(upd_idx)] == $past(cur_ctr))); // R9

endmodule

// File: rtl/tbp_hist_table.sv
module tbp_hist_table #(
    parameter int IDX_W  = 10,
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic              upd_taken,
    output logic [HIST_W-1:0] upd_hist
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic              en;
        logic [IDX_W-1:0]  idx;
        logic [HIST_W-1:0] val;
    } wr_t;

    logic [HIST_W-1:0] mem_q [DEPTH];
    wr_t               wr_d;

    always_comb begin
        upd_hist = mem_q[upd_idx];
        wr_d.en  = upd_en;
        wr_d.idx = upd_idx;
        wr_d.val = {upd_hist[HIST_W-2:0], upd_taken};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_d.en) begin
            mem_q[wr_d.idx] <= wr_d.val;
        end
    end

    assign rd_hist = mem_q[rd_idx];

    AST_HIST_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (mem_q[$past(upd_idx)][0] == $past(upd_taken))); // R5
    AST_HIST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> (mem_q[$past(upd_idx)] == $past(upd_hist))); // R9

endmodule

// File: rtl/tbp_choice_ctl.sv
module tbp_choice_ctl
    import tbp_pkg::*;
(
    input  logic  global_taken,
    input  logic  local_taken,
    input  logic  outcome,
    input  logic  valid,
    output logic  step_en,
    output side_e step_dir
);
    always_comb begin
        step_en  = valid && only_one_right(global_taken, local_taken, outcome);
        step_dir = (local_taken == outcome) ? SIDE_LOCAL : SIDE_GLOBAL;
    end

    AST_CHOICE_QUIET: assert final (!(valid && (global_taken == local_taken)) || !step_en); // R6

endmodule

// File: rtl/tournament_bp.sv
module tournament_bp
    import tbp_pkg::*;
#(
    parameter int PC_W         = 32,
    parameter int ALIGN_W      = 2,
    parameter int GHIST_W      = 10,
    parameter int CHOOSE_IDX_W = 10,
    parameter int LHT_IDX_W    = 10,
    parameter int LHIST_W      = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    output logic            lk_use_local,
    output logic            lk_global_taken,
    output logic            lk_local_taken,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken
);
    localparam int GCTR_W = 2;
    localparam int LCTR_W = 3;
    localparam int SEL_W  = 2;

    typedef struct packed {
        logic [GHIST_W-1:0] ghr;
    } state_t;

    state_t state_d, state_q;

    logic [CHOOSE_IDX_W-1:0] lk_sel_idx, up_sel_idx;
    logic [LHT_IDX_W-1:0]    lk_lht_idx, up_lht_idx;
    logic [LHIST_W-1:0]      lk_lhist, up_lhist;
    logic                    up_g_guess, up_l_guess;
    logic                    sel_step_en;
    side_e                   sel_step_dir;
    logic                    unused_sel_guess;
    logic                    unused_pc_bits;

    assign lk_sel_idx = lk_pc[ALIGN_W +: CHOOSE_IDX_W];
    assign up_sel_idx = up_pc[ALIGN_W +: CHOOSE_IDX_W];
    assign lk_lht_idx = lk_pc[ALIGN_W +: LHT_IDX_W];
    assign up_lht_idx = up_pc[ALIGN_W +: LHT_IDX_W];
    assign unused_pc_bits = ^{lk_pc, up_pc};

    always_comb begin
        state_d = state_q;
        if (up_valid) begin
            state_d.ghr = {state_q.ghr[GHIST_W-2:0], up_taken};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    tbp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W), .RST_VAL(1)) u_global (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (state_q.ghr),
        .rd_taken  (lk_global_taken),
        .upd_en    (up_valid),
        .upd_idx   (state_q.ghr),
        .upd_up    (up_taken),
        .upd_taken (up_g_guess)
    );

    tbp_hist_table #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) u_lhist (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (lk_lht_idx),
        .rd_hist   (lk_lhist),
        .upd_en    (up_valid),
        .upd_idx   (up_lht_idx),
        .upd_taken (up_taken),
        .upd_hist  (up_lhist)
    );

    tbp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W), .RST_VAL(3)) u_local (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (lk_lhist),
        .rd_taken  (lk_local_taken),
        .upd_en    (up_valid),
        .upd_idx   (up_lhist),
        .upd_up    (up_taken),
        .upd_taken (up_l_guess)
    );

    tbp_choice_ctl u_choice (
        .global_taken (up_g_guess),
        .local_taken  (up_l_guess),
        .outcome      (up_taken),
        .valid        (up_valid),
        .step_en      (sel_step_en),
        .step_dir     (sel_step_dir)
    );

    tbp_ctr_table #(.IDX_W(CHOOSE_IDX_W), .CTR_W(SEL_W), .RST_VAL(1)) u_select (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (lk_sel_idx),
        .rd_taken  (lk_use_local),
        .upd_en    (sel_step_en),
        .upd_idx   (up_sel_idx),
        .upd_up    (sel_step_dir == SIDE_LOCAL),
        .upd_taken (unused_sel_guess)
    );

    assign lk_taken = lk_use_local ? lk_local_taken : lk_global_taken;

    AST_GHR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(state_q.ghr)); // R9
    AST_GHR_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |=> (state_q.ghr[0] == $past(up_taken))); // R4
    AST_FINAL_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_global_taken == lk_local_taken) |-> (lk_taken == lk_global_taken)); // R7

endmodule

// File: tb/tournament_bp_tb_top.sv
module tournament_bp_tb_top;
    localparam int PC_W   = 32;
    localparam int ALIGN  = 2;
    localparam int GH_W   = 10;
    localparam int CH_W   = 10;
    localparam int LT_W   = 10;
    localparam int LH_W   = 10;
    localparam int NVEC   = 32;

    // {pc[15:0], taken}
    localparam logic [16:0] VEC [NVEC] = '{
        {16'h0200, 1'b1}, {16'h0300, 1'b1}, {16'h0404, 1'b1}, {16'h0200, 1'b0},
        {16'h0300, 1'b1}, {16'h0404, 1'b0}, {16'h0200, 1'b1}, {16'h0300, 1'b1},
        {16'h0404, 1'b1}, {16'h0200, 1'b0}, {16'h0300, 1'b0}, {16'h0404, 1'b0},
        {16'h0200, 1'b1}, {16'h0300, 1'b1}, {16'h0404, 1'b1}, {16'h0200, 1'b0},
        {16'h0300, 1'b1}, {16'h0404, 1'b0}, {16'h0200, 1'b1}, {16'h0300, 1'b1},
        {16'h0404, 1'b1}, {16'h0200, 1'b0}, {16'h0300, 1'b1}, {16'h0404, 1'b0},
        {16'h0508, 1'b1}, {16'h0508, 1'b1}, {16'h0508, 1'b0}, {16'h0508, 1'b1},
        {16'h0200, 1'b1}, {16'h0300, 1'b0}, {16'h0404, 1'b1}, {16'h0200, 1'b0}
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic [PC_W-1:0] lk_pc;
    logic            lk_taken, lk_use_local, lk_global_taken, lk_local_taken;
    logic            up_valid;
    logic [PC_W-1:0] up_pc;
    logic            up_taken;

    int errors = 0;
    int checks = 0;

    // Reference state derived from the requirements.
    logic [1:0]      m_g   [1 << GH_W];
    logic [2:0]      m_l   [1 << LH_W];
    logic [1:0]      m_s   [1 << CH_W];
    logic [LH_W-1:0] m_lht [1 << LT_W];
    logic [GH_W-1:0] m_ghr;

    always #5 clk = ~clk;

    tournament_bp dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .lk_pc           (lk_pc),
        .lk_taken        (lk_taken),
        .lk_use_local    (lk_use_local),
        .lk_global_taken (lk_global_taken),
        .lk_local_taken  (lk_local_taken),
        .up_valid        (up_valid),
        .up_pc           (up_pc),
        .up_taken        (up_taken)
    );

    task automatic check(input logic got, input logic exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b (t=%0t)", req, what, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < (1 << GH_W); i++) m_g[i] = 2'd1;
        for (int i = 0; i < (1 << LH_W); i++) m_l[i] = 3'd3;
        for (int i = 0; i < (1 << CH_W); i++) m_s[i] = 2'd1;
        for (int i = 0; i < (1 << LT_W); i++) m_lht[i] = '0;
        m_ghr = '0;
    endtask

    task automatic model_predict(input logic [PC_W-1:0] pc, output logic g, output logic l,
                                 output logic sel, output logic fin);
        logic [LH_W-1:0] pat;
        pat = m_lht[pc[ALIGN +: LT_W]];
        g   = (m_g[m_ghr] >= 2'd2);
        l   = (m_l[pat] >= 3'd4);
        sel = (m_s[pc[ALIGN +: CH_W]] >= 2'd2);
        fin = sel ? l : g;
    endtask

    task automatic model_update(input logic [PC_W-1:0] pc, input logic t);
        logic [LH_W-1:0] pat;
        logic g, l;
        int si;
        pat = m_lht[pc[ALIGN +: LT_W]];
        si  = int'(pc[ALIGN +: CH_W]);
        g   = (m_g[m_ghr] >= 2'd2);
        l   = (m_l[pat] >= 3'd4);
        if (t && m_g[m_ghr] != 2'd3) m_g[m_ghr] = m_g[m_ghr] + 2'd1;
        if (!t && m_g[m_ghr] != 2'd0) m_g[m_ghr] = m_g[m_ghr] - 2'd1;
        if (t && m_l[pat] != 3'd7) m_l[pat] = m_l[pat] + 3'd1;
        if (!t && m_l[pat] != 3'd0) m_l[pat] = m_l[pat] - 3'd1;
        if ((l == t) && (g != t) && m_s[si] != 2'd3) m_s[si] = m_s[si] + 2'd1;
        if ((g == t) && (l != t) && m_s[si] != 2'd0) m_s[si] = m_s[si] - 2'd1;
        m_lht[pc[ALIGN +: LT_W]] = {pat[LH_W-2:0], t};
        m_ghr = {m_ghr[GH_W-2:0], t};
    endtask

    // Drive at the falling edge; lookup results are settled 1 ns later.
    task automatic compare_lookup(input logic [PC_W-1:0] pc, input string req);
        logic g, l, s, f;
        model_predict(pc, g, l, s, f);
        check(lk_global_taken, g, req, "global guess");
        check(lk_local_taken,  l, req, "local guess");
        check(lk_use_local,    s, req, "selector");
        check(lk_taken,        f, "R7", "final");
    endtask

    task automatic step(input logic [PC_W-1:0] pc, input logic t, input string req);
        @(negedge clk);
        lk_pc    = pc;
        up_valid = 1'b1;
        up_pc    = pc;
        up_taken = t;
        #1;
        compare_lookup(pc, req);   // R8: pre-update state visible this cycle
        @(posedge clk);
        model_update(pc, t);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        up_valid = 1'b0;
        up_pc    = '0;
        up_taken = 1'b0;
        lk_pc    = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic a_last;
        logic p3_local;
        rst_n = 1'b0;
        apply_reset();

        // R1: reset state seen through lookups
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            lk_pc = PC_W'(32'h1000 + k * 32'h44);
            #1;
            check(lk_taken,        1'b0, "R1", "final after reset");
            check(lk_use_local,    1'b0, "R1", "selector after reset");
            check(lk_global_taken, 1'b0, "R1", "global after reset");
            check(lk_local_taken,  1'b0, "R1", "local after reset");
        end

        // Vector table: mixed branches, R2 R4 R5 R6
        for (int v = 0; v < NVEC; v++) begin
            step(PC_W'(VEC[v][16:1]), VEC[v][0], "R2/R4");
        end

        // Long patterned run: alternating, mostly taken, correlated (R3 R5 R6)
        a_last = 1'b0;
        for (int i = 0; i < 600; i++) begin
            case (i % 3)
                0: begin
                    a_last = ~a_last;
                    step(PC_W'(32'h0600), a_last, "R5");
                end
                1: step(PC_W'(32'h0704), (i % 7) != 0, "R6");
                default: step(PC_W'(32'h0808), a_last, "R4");
            endcase
        end

        // R9: idle cycles with toggling update data change nothing
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            up_valid = 1'b0;
            up_pc    = PC_W'(32'h0600 + i * 4);
            up_taken = i[0];
        end
        foreach (VEC[v]) begin
            if (v < 4) begin
                @(negedge clk);
                lk_pc = PC_W'(32'h0600 + v * 32'h104);
                #1;
                compare_lookup(lk_pc, "R9");
            end
        end

        // R3: four PCs drive a shared all-ones pattern to saturation, then three decrements
        apply_reset();
        for (int p = 0; p < 4; p++) begin
            for (int n = 0; n < 12; n++) begin
                step(PC_W'(32'h0100 + p * 4), 1'b1, "R3");
            end
        end
        for (int p = 0; p < 3; p++) begin
            step(PC_W'(32'h0100 + p * 4), 1'b0, "R3");
        end
        @(negedge clk);
        up_valid = 1'b0;
        lk_pc    = PC_W'(32'h010C);
        #1;
        p3_local = lk_local_taken;
        check(p3_local, 1'b1, "R3", "local counter after saturate then 3 steps down");
        compare_lookup(lk_pc, "R3");

        // R8: an update is visible from the next edge
        step(PC_W'(32'h010C), 1'b0, "R8");
        @(negedge clk);
        up_valid = 1'b0;
        lk_pc    = PC_W'(32'h010C);
        #1;
        compare_lookup(lk_pc, "R8");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule